// File: doc/BRIEF.md
# Multi-mode 4-input function generator

This block is a 16-bit configurable logic cell built around one shared storage array. A static mode select sets how the four address inputs and the write path act on that array. As a lookup table, the stored bits are a truth table: the four inputs select one bit, so any boolean function of four variables is available, and the output delay is the same for every function. As a distributed memory, the cell is a 16x1 RAM with a clocked write and a combinational read at the same address. As a shift register, each enabled clock moves the contents up one place, and the address inputs select a tap. The topmost bit also leaves the cell as a cascade output.

The array is loaded from the `INIT` parameter while reset is asserted, in every mode. A lookup-table function is fixed by choosing `INIT`. The mode may only change while reset is held. The combinational output can feed cell logic directly or drive the data input of a downstream flip-flop.

Top module: `cfgcell_fgen`

## Requirements
- R1: While `rst_n` is low, the 16 stored bits take the value of the `INIT` parameter, whatever the mode.
- R2: `lut_out` is the stored bit whose index is the value of `addr`, with `addr[0]` as the least significant bit. It follows `addr` combinationally, with no clock, in every mode.
- R3: In lookup mode (`mode_sel` = 2'b00), `wr_en` and `din` have no effect on the stored bits.
- R4: The reserved code `mode_sel` = 2'b11 behaves exactly like lookup mode, and the stored bits never change.
- R5: In RAM mode (`mode_sel` = 2'b01), a rising clock edge with `wr_en` high writes `din` into the bit at index `addr` and leaves the other 15 bits unchanged.
- R6: In RAM mode, a rising edge with `wr_en` low leaves every stored bit unchanged.
- R7: In shift mode (`mode_sel` = 2'b10), a rising edge with `wr_en` high moves bit i to bit i+1 for i = 0..14, loads `din` into bit 0 and discards the old bit 15.
- R8: In shift mode, a rising edge with `wr_en` low leaves every stored bit unchanged.
- R9: In shift mode, with `addr` = a, `lut_out` equals the `din` value shifted in a+1 enabled shifts earlier.
- R10: `casc_out` always equals stored bit 15, independent of `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and shifts happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads `INIT` |
| mode_sel | input | 2 | 00 lookup, 01 RAM, 10 shift, 11 reserved (acts as lookup) |
| wr_en | input | 1 | Write enable in RAM mode, shift enable in shift mode |
| din | input | 1 | Bit to write or to shift in |
| addr | input | 4 | Function inputs, RAM address or shift tap |
| lut_out | output | 1 | Selected stored bit |
| casc_out | output | 1 | Stored bit 15, for chaining shift registers |

## Verification
The lookup function is checked with a non-symmetric truth table swept over all 16 input combinations, before and after enabled writes are attempted. This separates a correct index from a reversed or shifted one, and a fixed table from one that is written. The reserved code gets the same treatment. The RAM is filled with an address-derived pattern and read back in full, then swept again with the enable low and inverted data, which shows whether the write is steered to the right bit and properly gated. Shift mode is fed a long pseudo-random stream, and every tap is compared after each step with both a bench shift model and a direct history of the input. This tells a correct tap delay of address+1 from an off-by-one, and it also confirms the hold behaviour and the cascade bit.

// File: rtl/cfgcell_pkg.sv
package cfgcell_pkg;
  typedef enum logic [1:0] {
    CELL_LOOKUP = 2'b00,
    CELL_RAM    = 2'b01,
    CELL_SHIFT  = 2'b10,
    CELL_RSVD   = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/cfgcell_ctl.sv
module cfgcell_ctl
  import cfgcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       wr_en,
  output logic       wr_stb,
  output logic       sh_stb
);
  cell_mode_e mode;

  assign mode   = cell_mode_e'(mode_sel);
  assign wr_stb = (mode == CELL_RAM)   && wr_en;
  assign sh_stb = (mode == CELL_SHIFT) && wr_en;

  // R3 R4: lookup and reserved codes never raise an update strobe
  assert_lookup_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 || mode_sel == 2'b11) |-> (!wr_stb && !sh_stb));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, sh_stb}));
endmodule

// File: rtl/cfgcell_store.sv
module cfgcell_store #(
  parameter int ADDR_W = 4,
  parameter logic [(1<<ADDR_W)-1:0] INIT = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic                     sh_stb,
  input  logic                     din,
  input  logic [ADDR_W-1:0]        addr,
  output logic [(1<<ADDR_W)-1:0]   bits
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DEPTH-1:0] ONE = {{(DEPTH-1){1'b0}}, 1'b1};

  function automatic logic [DEPTH-1:0] put_bit(input logic [DEPTH-1:0] v,
                                               input logic [ADDR_W-1:0] a,
                                               input logic d);
    logic [DEPTH-1:0] r;
    r    = v;
    r[a] = d;
    return r;
  endfunction

  function automatic logic [DEPTH-1:0] push_up(input logic [DEPTH-1:0] v,
                                               input logic d);
    return {v[DEPTH-2:0], d};
  endfunction

  logic [DEPTH-1:0] keep_mask;
  assign keep_mask = ~(ONE << addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits <= INIT;
    else if (sh_stb) bits <= push_up(bits, din);
    else if (wr_stb) bits <= put_bit(bits, addr, din);
  end

  assert_ram_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> bits[$past(addr)] == $past(din));

  assert_ram_others_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ((bits ^ $past(bits)) & $past(keep_mask)) == '0);

  assert_shift_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_stb |=> (bits[0] == $past(din)) && (bits[DEPTH-1:1] == $past(bits[DEPTH-2:0])));

  // R6 R8: no strobe means the array holds
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !sh_stb) |=> $stable(bits));
endmodule

// File: rtl/cfgcell_tap.sv
module cfgcell_tap #(
  parameter int ADDR_W = 4
) (
  input  logic [(1<<ADDR_W)-1:0] bits,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   lut_out,
  output logic                   casc_out
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic pick(input logic [DEPTH-1:0] v,
                                input logic [ADDR_W-1:0] a);
    return v[a];
  endfunction

  assign lut_out  = pick(bits, addr);
  assign casc_out = bits[DEPTH-1];
endmodule

// File: rtl/cfgcell_fgen.sv
module cfgcell_fgen #(
  parameter int ADDR_W = 4,
  parameter logic [(1<<ADDR_W)-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              wr_en,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  output logic              lut_out,
  output logic              casc_out
);
  localparam int DEPTH = 1 << ADDR_W;

  logic             wr_stb;
  logic             sh_stb;
  logic [DEPTH-1:0] bits;

  cfgcell_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .wr_en    (wr_en),
    .wr_stb   (wr_stb),
    .sh_stb   (sh_stb)
  );

  cfgcell_store #(.ADDR_W(ADDR_W), .INIT(INIT)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .sh_stb (sh_stb),
    .din    (din),
    .addr   (addr),
    .bits   (bits)
  );

  cfgcell_tap #(.ADDR_W(ADDR_W)) u_tap (
    .bits     (bits),
    .addr     (addr),
    .lut_out  (lut_out),
    .casc_out (casc_out)
  );

  // R10: after a shift the cascade bit is the old bit below it
  assert_casc_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sh_stb |=> casc_out == $past(bits[DEPTH-2]));

  // R4: reserved code keeps the cascade bit steady
  assert_rsvd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> $stable(casc_out));
endmodule

// File: tb/test_cfgcell_fgen.sv
module test_cfgcell_fgen;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TT = 16'hB3C5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       wr_en = 1'b0;
  logic       din = 1'b0;
  logic [3:0] addr = 4'd0;
  logic       lut_out;
  logic       casc_out;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgcell_fgen #(.ADDR_W(4), .INIT(TT)) i_cfgcell_fgen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_en(wr_en),
    .din(din), .addr(addr), .lut_out(lut_out), .casc_out(casc_out)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (addr %0d)", req, got, exp, addr);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; wr_en = 1'b0; din = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sweep(input string req, input logic [15:0] exp);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #1;
      check(req, lut_out, exp[a]);
    end
    check("R10", casc_out, exp[15]);
  endtask

  // one clock with given enable and data, inputs changed on the falling edge
  task automatic pulse(input logic e, input logic d, input logic [3:0] a);
    @(negedge clk);
    wr_en = e; din = d; addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic ram_pat(input int a);
    return 1'(((a * 7) ^ (a >> 1)) & 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] model;
    logic [15:0] ram_exp;
    logic [7:0]  lfsr;
    logic        hist [0:63];
    int          nsh;

    // R1 R2: reset loads the table, full sweep in lookup mode
    do_reset(2'b00);
    sweep("R1", TT);
    // R3: attempted writes in lookup mode do nothing
    for (int a = 0; a < 16; a++) pulse(1'b1, ~TT[a], 4'(a));
    sweep("R3", TT);

    // R4: reserved code behaves as lookup
    do_reset(2'b11);
    for (int a = 0; a < 16; a++) pulse(1'b1, ~TT[a], 4'(15 - a));
    sweep("R4", TT);

    // R5: RAM fill and readback
    do_reset(2'b01);
    sweep("R2", TT);
    ram_exp = TT;
    for (int a = 0; a < 16; a++) begin
      pulse(1'b1, ram_pat(a), 4'(a));
      ram_exp[a] = ram_pat(a);
      sweep("R5", ram_exp);
      if (a == 7) a = a;
    end
    // R6: enable low, inverted data, no change
    for (int a = 0; a < 16; a++) pulse(1'b0, ~ram_pat(a), 4'(a));
    sweep("R6", ram_exp);
    // R5: single overwrite at the top address, others kept
    pulse(1'b1, ~ram_exp[15], 4'd15);
    ram_exp[15] = ~ram_exp[15];
    sweep("R5", ram_exp);

    // R7 R8 R9: shift mode with a pseudo-random stream
    do_reset(2'b10);
    model = TT;
    lfsr  = 8'hA5;
    nsh   = 0;
    for (int k = 0; k < 48; k++) begin
      logic bitin;
      bitin = lfsr[0];
      lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pulse(1'b1, bitin, 4'd0);
      hist[nsh] = bitin;
      nsh++;
      model = {model[14:0], bitin};
      sweep("R7", model);
      for (int a = 0; a < 16; a++) begin
        if (nsh > a) begin
          addr = 4'(a);
          #1;
          check("R9", lut_out, hist[nsh - 1 - a]);
        end
      end
      if (k % 8 == 3) begin
        pulse(1'b0, ~bitin, 4'd5);
        sweep("R8", model);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule